// File: doc/BRIEF.md
# Converter Offset and Gain Calibration Engine

This block sits behind the decimation filter of an oversampling converter. On request it runs a self-contained calibration. It first steers the modulator input selector to short the two inputs together and averages eight settled filter results into an offset value. It then steers the selector to put the reference on the positive input and ground on the negative input, averages eight more settled results, and turns their distance from the offset into an unsigned gain factor with a sequential divider. Settling is modelled as a fixed count of discarded results before each averaging window.

Outside calibration, every filter result has the stored offset removed and the difference scaled by the gain factor. The corrected word saturates to the signed output range. Two independent correction banks exist, one for unipolar and one for bipolar input mode. A calibration writes the bank of the mode that was selected when it started, and the live mode picks the bank that corrects the data. A rising sync edge or a standby request ends a running calibration at once and leaves both banks as they were.

Top module: `cal_engine`

## Requirements
- R1: Synchronous active-high reset clears both banks to zero offset and zero gain, sets `mux_sel` to 0 (normal input), and drops `busy` and `dout_vld`. Before any calibration every corrected output is therefore 0.
- R2: `cal_start` while idle and out of standby raises `busy` on the next cycle with `mux_sel` = 1 (inputs shorted). The first SETTLE_N valid results are discarded, and the offset is floor(sum of the next 8 results / 8).
- R3: After the offset window `mux_sel` = 2 (reference on the positive input, ground on the negative input). SETTLE_N more results are discarded and the next 8 are averaged the same way into G. The gain is min(65535, floor(16384 * 2^14 / (G - offset))), and it is 65535 when G - offset <= 0. Unity gain is 2^14.
- R4: `mux_sel` stays 2 until both correction values are written. `busy` then falls and `mux_sel` returns to 0 in the same cycle.
- R5: When not busy, a result with `din_vld` gives `dout_vld` one cycle later with `dout` = floor((din - offset) * gain / 2^14).
- R6: A corrected value above 32767 or below -32768 is output as 32767 or -32768.
- R7: `mode_bipolar` (0 unipolar, 1 bipolar) sampled at `cal_start` picks the bank that is written, and changing it during calibration has no effect on that choice. The live `mode_bipolar` picks the bank used for correction.
- R8: A rising edge of `sync_req` while busy ends calibration: `busy` is 0 and `mux_sel` is 0 on the next cycle, and both banks are unchanged. A `sync_req` held high with no new rising edge does not end calibration.
- R9: `stby_req` high while busy ends calibration the same way. `cal_start` is ignored while `stby_req` is high. The banks keep their contents through standby.
- R10: While busy, no corrected result is produced (`dout_vld` stays 0), and a further `cal_start` does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_bipolar | input | 1 | Input mode: 0 unipolar, 1 bipolar |
| cal_start | input | 1 | Start-calibration request |
| sync_req | input | 1 | Sync request; a rising edge aborts calibration |
| stby_req | input | 1 | Standby request; aborts calibration, blocks start |
| din | input | 16 | Signed filter result |
| din_vld | input | 1 | Filter result strobe |
| mux_sel | output | 2 | Input selector: 0 normal, 1 shorted, 2 reference/ground |
| busy | output | 1 | Calibration running; output data held off |
| dout | output | 16 | Signed corrected result |
| dout_vld | output | 1 | Corrected result strobe |

## Verification
A wrong settle or averaging count shows up as a stored offset or gain that differs from the bench model. The error appears on the first corrected word after `busy` falls, one cycle after its input. A selector or sequencer fault shows at `mux_sel` on the first result of the affected phase. A bank written with the wrong mode, or an abort that corrupts a bank, is exposed by corrected words in both modes after the event. A failed abort shows as `busy` still high one cycle after the sync edge or the standby request.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [1:0] {
        MUX_NORMAL = 2'd0,
        MUX_SHORT  = 2'd1,
        MUX_REF    = 2'd2
    } mux_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF_SET,
        ST_OFF_AVG,
        ST_GAIN_SET,
        ST_GAIN_AVG,
        ST_DIV_GO,
        ST_DIV
    } cal_state_e;

    // Input selector setting for each sequencer state; the reference stays
    // applied until the gain division completes and the banks are written.
    function automatic mux_e mux_for(cal_state_e s);
        case (s)
            ST_OFF_SET, ST_OFF_AVG:                    return MUX_SHORT;
            ST_GAIN_SET, ST_GAIN_AVG, ST_DIV_GO, ST_DIV: return MUX_REF;
            default:                                   return MUX_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/cal_div.sv
module cal_div #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 16,
    parameter int Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int SW = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem;
    logic [NUM_W-1:0] q;
    logic [SW-1:0]    step;
    logic             running;
    logic [DEN_W:0]   rem_sh;
    logic             fits;

    assign rem_sh = {rem[DEN_W-1:0], q[NUM_W-1]};
    assign fits   = (rem_sh >= {1'b0, den});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rem     <= '0;
            q       <= '0;
            step    <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem     <= '0;
                q       <= num;
                step    <= '0;
                running <= 1'b1;
            end else if (running) begin
                rem  <= fits ? (rem_sh - {1'b0, den}) : rem_sh;
                q    <= {q[NUM_W-2:0], fits};
                step <= step + 1'b1;
                if (step == SW'(NUM_W - 1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // Quotient clamps to the largest gain code when it does not fit.
    assign quo = (|q[NUM_W-1:Q_W]) ? '1 : q[Q_W-1:0];

    assert_div_runs_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !clr) |=> running);

endmodule

// File: rtl/cal_apply.sv
module cal_apply #(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] din,
    input  logic signed [DATA_W-1:0] off,
    input  logic [GAIN_W-1:0]        gain,
    output logic signed [DATA_W-1:0] dout,
    output logic                     dout_vld
);
    localparam int PW = DATA_W + GAIN_W + 2;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic signed [DATA_W:0]   diff;
    logic signed [GAIN_W:0]   gain_s;
    logic signed [PW-1:0]     diff_x, gain_x, prod, scl;
    logic signed [DATA_W-1:0] sat;

    always_comb begin
        diff   = {din[DATA_W-1], din} - {off[DATA_W-1], off};
        gain_s = {1'b0, gain};
        diff_x = PW'(diff);
        gain_x = PW'(gain_s);
        prod   = diff_x * gain_x;
        scl    = prod >>> GAIN_FRAC;
        if (scl > MAXV)      sat = MAXV[DATA_W-1:0];
        else if (scl < MINV) sat = MINV[DATA_W-1:0];
        else                 sat = scl[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= in_vld;
            if (in_vld) dout <= sat;
        end
    end

    assert_out_follows_R5: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> $past(in_vld));

endmodule

// File: rtl/cal_engine.sv
module cal_engine
    import cal_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int SETTLE_N  = 4,
    parameter int AVG_LOG2  = 3,
    parameter int FS_TARGET = 16384
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_bipolar,
    input  logic                     cal_start,
    input  logic                     sync_req,
    input  logic                     stby_req,
    input  logic signed [DATA_W-1:0] din,
    input  logic                     din_vld,
    output logic [1:0]               mux_sel,
    output logic                     busy,
    output logic signed [DATA_W-1:0] dout,
    output logic                     dout_vld
);
    localparam int AVG_N  = 1 << AVG_LOG2;
    localparam int ACC_W  = DATA_W + AVG_LOG2;
    localparam int NUM_W  = DATA_W + GAIN_FRAC;
    localparam int CNT_MX = (SETTLE_N > AVG_N) ? SETTLE_N : AVG_N;
    localparam int CNT_W  = $clog2(CNT_MX + 1);
    localparam logic [NUM_W-1:0] DIV_NUM = NUM_W'(FS_TARGET) << GAIN_FRAC;

    cal_state_e                state;
    logic [CNT_W-1:0]          cnt;
    logic signed [ACC_W-1:0]   acc, acc_sum;
    logic signed [DATA_W-1:0]  avg_val;
    logic                      cal_mode;
    logic signed [DATA_W-1:0]  off_new, gain_avg;
    logic signed [DATA_W-1:0]  off_reg [2];
    logic [GAIN_W-1:0]         gain_reg [2];
    logic                      sync_q, sync_rise, abort;
    logic                      last_settle, last_avg;
    logic signed [DATA_W:0]    span;
    logic [DATA_W-1:0]         div_den;
    logic                      div_done;
    logic [GAIN_W-1:0]         div_quo;

    assign busy      = (state != ST_IDLE);
    assign mux_sel   = mux_for(state);
    assign sync_rise = sync_req & ~sync_q;
    assign abort     = busy & (sync_rise | stby_req);

    assign last_settle = (cnt == CNT_W'(SETTLE_N - 1));
    assign last_avg    = (cnt == CNT_W'(AVG_N - 1));
    assign acc_sum     = acc + ACC_W'(din);
    assign avg_val     = DATA_W'(acc_sum >>> AVG_LOG2);

    // Distance from the offset to the reference average; non-positive spans
    // divide by zero, which the divider turns into the largest gain code.
    assign span    = {gain_avg[DATA_W-1], gain_avg} - {off_new[DATA_W-1], off_new};
    assign div_den = (span > 0) ? span[DATA_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            acc         <= '0;
            cal_mode    <= 1'b0;
            off_new     <= '0;
            gain_avg    <= '0;
            off_reg[0]  <= '0;
            off_reg[1]  <= '0;
            gain_reg[0] <= '0;
            gain_reg[1] <= '0;
            sync_q      <= 1'b0;
        end else begin
            sync_q <= sync_req;
            if (abort) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (cal_start && !stby_req) begin
                        state    <= ST_OFF_SET;
                        cal_mode <= mode_bipolar;
                        cnt      <= '0;
                    end
                    ST_OFF_SET, ST_GAIN_SET: if (din_vld) begin
                        if (last_settle) begin
                            state <= (state == ST_OFF_SET) ? ST_OFF_AVG : ST_GAIN_AVG;
                            cnt   <= '0;
                            acc   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_OFF_AVG, ST_GAIN_AVG: if (din_vld) begin
                        if (last_avg) begin
                            cnt <= '0;
                            if (state == ST_OFF_AVG) begin
                                off_new <= avg_val;
                                state   <= ST_GAIN_SET;
                            end else begin
                                gain_avg <= avg_val;
                                state    <= ST_DIV_GO;
                            end
                        end else begin
                            acc <= acc_sum;
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DIV_GO: state <= ST_DIV;
                    ST_DIV: if (div_done) begin
                        off_reg[cal_mode]  <= off_new;
                        gain_reg[cal_mode] <= div_quo;
                        state              <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    cal_div #(
        .NUM_W (NUM_W),
        .DEN_W (DATA_W),
        .Q_W   (GAIN_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .clr   (abort),
        .start (state == ST_DIV_GO),
        .num   (DIV_NUM),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    cal_apply #(
        .DATA_W    (DATA_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_apply (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (din_vld & ~busy),
        .din      (din),
        .off      (off_reg[mode_bipolar]),
        .gain     (gain_reg[mode_bipolar]),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    assert_enter_short_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mux_sel == MUX_SHORT));

    assert_sync_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && sync_req && !sync_q) |=> !busy);

    assert_banks_kept_R8: assert property (@(posedge clk) disable iff (rst)
        abort |=> ($stable(off_reg[0]) && $stable(off_reg[1]) &&
                   $stable(gain_reg[0]) && $stable(gain_reg[1])));

    assert_stby_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && stby_req) |=> !busy);

    assert_stby_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && stby_req) |=> !busy);

    assert_quiet_busy_R10: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> $past(!busy));

endmodule

// File: tb/cal_engine_bench.sv
module cal_engine_bench;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_bipolar = 1'b0, cal_start = 1'b0, sync_req = 1'b0, stby_req = 1'b0;
    logic signed [15:0] din = '0;
    logic din_vld = 1'b0;
    logic [1:0] mux_sel;
    logic busy, dout_vld;
    logic signed [15:0] dout;

    int total = 0;
    int bad = 0;
    longint m_off [2];
    longint m_gain [2];

    always #2 clk = ~clk;

    cal_engine u_cal_engine (
        .clk(clk), .rst(rst), .mode_bipolar(mode_bipolar), .cal_start(cal_start),
        .sync_req(sync_req), .stby_req(stby_req), .din(din), .din_vld(din_vld),
        .mux_sel(mux_sel), .busy(busy), .dout(dout), .dout_vld(dout_vld));

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint f_gain(longint off, longint gavg);
        longint d = gavg - off;
        longint q;
        if (d <= 0) return 65535;
        q = (longint'(16384) << 14) / d;
        return (q > 65535) ? 65535 : q;
    endfunction

    function automatic longint f_corr(longint x, longint off, longint gain);
        longint s = ((x - off) * gain) >>> 14;
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    task automatic check_out(longint x, string req);
        longint e = f_corr(x, m_off[mode_bipolar], m_gain[mode_bipolar]);
        din = 16'(x); din_vld = 1'b1;
        @(negedge clk);
        din_vld = 1'b0;
        chk({req, " vld"}, dout_vld, 1);
        chk(req, longint'(dout), e);
    endtask

    // Full calibration; extra start pulse mid-run when restart_poke is set,
    // live mode flips after start when flip is set.
    task automatic run_cal(bit md, int ob, int gb, int sp, int gap, bit flip, bit restart_poke);
        longint sum [2];
        longint avg [2];
        int base;
        sum[0] = 0; sum[1] = 0;
        mode_bipolar = md;
        @(negedge clk); cal_start = 1'b1;
        @(negedge clk); cal_start = 1'b0;
        chk("R2 busy after start", busy, 1);
        if (flip) mode_bipolar = ~md;
        for (int ph = 0; ph < 2; ph++) begin
            base = (ph == 0) ? ob : gb;
            chk(ph == 0 ? "R2 mux shorted" : "R3 mux reference", mux_sel, ph == 0 ? 1 : 2);
            for (int i = 0; i < S + 8; i++) begin
                longint v;
                if (i < S) v = (i % 2 == 0) ? 32767 : -32768;
                else begin
                    v = base + longint'($urandom_range(0, 2 * sp)) - sp;
                    sum[ph] += v;
                end
                din = 16'(v); din_vld = 1'b1;
                if (restart_poke && ph == 0 && i == S + 2) cal_start = 1'b1;
                @(negedge clk);
                din_vld = 1'b0; cal_start = 1'b0;
                if (i == 0) chk("R10 no output while busy", dout_vld, 0);
                repeat (gap) @(negedge clk);
            end
        end
        avg[0] = sum[0] >>> 3;
        avg[1] = sum[1] >>> 3;
        chk("R4 reference held until written", mux_sel, 2);
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
        chk("R4 busy released", busy, 0);
        chk("R4 mux back to normal", mux_sel, 0);
        m_off[md]  = avg[0];
        m_gain[md] = f_gain(avg[0], avg[1]);
        mode_bipolar = md;
    endtask

    task automatic abort_after(int n, bit use_sync);
        mode_bipolar = 1'b0;
        @(negedge clk); cal_start = 1'b1;
        @(negedge clk); cal_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            din = 16'(100 + i); din_vld = 1'b1;
            @(negedge clk);
            din_vld = 1'b0;
        end
        if (use_sync) sync_req = 1'b1; else stby_req = 1'b1;
        @(negedge clk);
        chk(use_sync ? "R8 sync aborts" : "R9 standby aborts", busy, 0);
        chk(use_sync ? "R8 mux normal" : "R9 mux normal", mux_sel, 0);
        sync_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_off[0] = 0; m_off[1] = 0; m_gain[0] = 0; m_gain[1] = 0;
        repeat (4) @(negedge clk);
        chk("R1 busy at reset", busy, 0);
        chk("R1 mux at reset", mux_sel, 0);
        chk("R1 dout_vld at reset", dout_vld, 0);
        rst = 1'b0;
        @(negedge clk);
        check_out(1000, "R1 uncalibrated output zero");
        check_out(-20000, "R1 uncalibrated output zero");

        // Unipolar calibration, back-to-back results, then random data.
        run_cal(1'b0, 50, 8000, 20, 0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++)
            check_out(longint'($urandom_range(0, 65535)) - 32768, "R5 corrected word");
        check_out(32767, "R6 positive clamp");
        check_out(-32768, "R6 negative clamp");

        // Bipolar calibration with gaps between results.
        run_cal(1'b1, -300, 16000, 40, 1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++)
            check_out(longint'($urandom_range(0, 65535)) - 32768, "R7 bipolar bank");
        mode_bipolar = 1'b0;
        for (int i = 0; i < 6; i++)
            check_out(longint'($urandom_range(0, 65535)) - 32768, "R7 unipolar bank kept");

        // Mode flipped during calibration: bank chosen at start.
        run_cal(1'b0, 10, 12000, 10, 0, 1'b1, 1'b0);
        check_out(5000, "R7 bank from start mode");
        mode_bipolar = 1'b1;
        check_out(5000, "R7 other bank untouched");

        // Non-positive span and tiny span both give the top gain code.
        run_cal(1'b0, 500, 100, 0, 0, 1'b0, 1'b0);
        chk("R3 gain for negative span", m_gain[0], 65535);
        check_out(600, "R3 top gain code");
        run_cal(1'b1, 200, 201, 0, 0, 1'b0, 1'b0);
        check_out(203, "R3 clamped quotient");

        // Start pulse during calibration is ignored.
        run_cal(1'b0, -40, 9000, 30, 0, 1'b0, 1'b1);
        check_out(1234, "R10 restart request ignored");

        // Sync edge abort and held sync.
        abort_after(6, 1'b1);
        mode_bipolar = 1'b0;
        check_out(-777, "R8 banks unchanged by abort");
        sync_req = 1'b1;
        repeat (2) @(negedge clk);
        run_cal(1'b1, 0, 4096, 15, 0, 1'b0, 1'b0);
        sync_req = 1'b0;
        check_out(3000, "R8 held sync does not abort");

        // Standby abort, start blocked in standby, banks retained.
        abort_after(S + 3, 1'b0);
        @(negedge clk); cal_start = 1'b1;
        @(negedge clk); cal_start = 1'b0;
        chk("R9 start ignored in standby", busy, 0);
        check_out(2500, "R9 banks kept through standby");
        stby_req = 1'b0;
        mode_bipolar = 1'b1;
        check_out(-2500, "R9 bipolar bank kept");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule